// File: doc/BRIEF.md
# UART Modem Handshake Section

This block is the per-channel modem-line section of a 16550-style serial port. A host writes a control register over an 8-bit register bus selected by a 3-bit address. The control bits drive the active-low terminal-ready and request-to-send pins and a general-purpose output. They also decide whether the channel interrupt pin is driven or left floating, and they switch the channel into internal loopback. The four active-low handshake inputs (data-set-ready, clear-to-send, carrier-detect, ring) are synchronised. Their asserted levels and change flags are presented in a status register that the host reads. A modem-status interrupt request is raised while any change flag is pending and the matching enable bit is set.

In loopback the serial receive pin is disconnected and the transmit stream feeds the receiver. The transmit pin idles high and the handshake outputs go inactive. The status inputs are then taken from the control bits, so software can exercise the whole status path without a cable. The interrupt pin is modelled as a data output plus an output enable; the pad's tri-state buffer sits outside this block.

Top module: `uart_modem_ctl`

## Requirements
- R1: While reset is active and until the host writes, `dtr_n_o`, `rts_n_o` and `op_n_o` are 1, `irq_oe_o` is 0, and the control (address 4), enable (address 1) and status (address 6) registers read 0. Reset is asynchronous when asserted and is released through a two-stage synchroniser.
- R2: Outside loopback, bit 0 of the control register drives `dtr_n_o` inverted: writing 1 gives 0 and writing 0 gives 1 on the cycle after the write.
- R3: Outside loopback, bit 1 of the control register drives `rts_n_o` inverted.
- R4: Bit 3 of the control register set makes `irq_oe_o` 1. Outside loopback it also makes `op_n_o` 0. With bit 3 clear, `irq_oe_o` is 0 and `op_n_o` is 1.
- R5: With bit 4 of the control register set (loopback), `rx_o` follows `tx_i` and ignores `rx_i`. In loopback, `tx_o`, `dtr_n_o`, `rts_n_o` and `op_n_o` are all 1. Outside loopback, `rx_o` follows `rx_i` and `tx_o` follows `tx_i`.
- R6: In loopback the four status levels come from the control register, and the pins are ignored. Carrier-detect comes from bit 3, ring from bit 2, data-set-ready from bit 0 and clear-to-send from bit 1. The levels take effect one cycle after the control register changes.
- R7: The status register holds four asserted levels (inverse of the pins) and four change flags. The levels sit in bits 7 (carrier-detect), 6 (ring), 5 (data-set-ready) and 4 (clear-to-send). The change flags sit in bits 3 (carrier-detect), 2 (ring trailing edge), 1 (data-set-ready) and 0 (clear-to-send). A pin change appears in the status register on the third rising clock edge after the change.
- R8: The carrier-detect, data-set-ready and clear-to-send change flags set on either direction of level change.
- R9: The ring change flag sets only when the ring pin goes from low to high (ring level deasserting). The high-to-low pin transition leaves it clear.
- R10: A read of the status register (`rd_en` at address 6) clears all four change flags at that clock edge. A change detected on the same edge still sets its flag.
- R11: `irq_o` is 1 exactly when bit 3 of the enable register is 1 and at least one change flag is set.
- R12: The control register keeps bits 4:0 and reads 0 in bits 7:5. The enable register keeps bits 3:0. Writes to the status address have no effect, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears change flags at the status address) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier-detect pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring pin, active low, asynchronous |
| tx_i | input | 1 | Serial stream from the transmit shifter |
| rx_i | input | 1 | Serial receive pin |
| rx_o | output | 1 | Serial stream to the receive shifter |
| tx_o | output | 1 | Serial transmit pin |
| dtr_n_o | output | 1 | Terminal-ready pin, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| op_n_o | output | 1 | General-purpose output pin |
| irq_o | output | 1 | Channel interrupt data |
| irq_oe_o | output | 1 | Output enable for the interrupt pad |

## Verification
The hardest state to reach is a change flag that is set and cleared on the same edge. This happens when a status read lands on the exact cycle a synchronised level moves. Loopback entry and exit also create many simultaneous flags that come from control writes rather than pins. Directed sequences walk each line through both edges and through loopback entry and exit. A long random phase then mixes pin toggles, status reads and control writes at random addresses. This lands reads on edge cycles many times, and a per-cycle reference model predicts every flag.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_W   = 8;
  localparam int LINES   = 4;
  localparam int CTL_W   = 5;
  localparam int IEN_W   = 4;

  // control bit positions
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_OUT1 = 2;
  localparam int CB_OUT2 = 3;
  localparam int CB_LOOP = 4;

  // line index within level and change vectors
  localparam int LN_CTS  = 0;
  localparam int LN_DSR  = 1;
  localparam int LN_RI   = 2;
  localparam int LN_DCD  = 3;

  // modem-status enable bit in the enable register
  localparam int IB_MDM  = 3;

  typedef logic [LINES-1:0] mdm_lines_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs import mdm_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ien_we,
  input  logic [CTL_W-1:0] wbits,
  output logic [CTL_W-1:0] ctl_q,
  output logic [IEN_W-1:0] ien_q
);
  logic [CTL_W-1:0] ctl_d;
  logic [IEN_W-1:0] ien_d;

  always_comb begin
    ctl_d = wbits;
    ien_d = wbits[IEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= ien_d;
  end
endmodule

// File: rtl/mdm_status.sv
module mdm_status import mdm_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  mdm_lines_t       pin_lvl,
  input  logic [CTL_W-1:0] ctl_q,
  input  logic             clr,
  output mdm_lines_t       lvl_q,
  output mdm_lines_t       dlt_q
);
  mdm_lines_t src, set, lvl_d, dlt_d;

  always_comb begin
    if (ctl_q[CB_LOOP]) begin
      src         = '0;
      src[LN_DCD] = ctl_q[CB_OUT2];
      src[LN_RI]  = ctl_q[CB_OUT1];
      src[LN_DSR] = ctl_q[CB_DTR];
      src[LN_CTS] = ctl_q[CB_RTS];
    end else begin
      src = pin_lvl;
    end
    set         = src ^ lvl_q;
    set[LN_RI]  = lvl_q[LN_RI] & ~src[LN_RI];
    lvl_d       = src;
    dlt_d       = (clr ? '0 : dlt_q) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      dlt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      dlt_q <= dlt_d;
    end
  end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl import mdm_pkg::*; #(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter logic [ADDR_W-1:0] ADDR_IEN = 3'd1,
  parameter logic [ADDR_W-1:0] ADDR_CTL = 3'd4,
  parameter logic [ADDR_W-1:0] ADDR_STS = 3'd6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              dsr_n_i,
  input  logic              cts_n_i,
  input  logic              dcd_n_i,
  input  logic              ri_n_i,
  input  logic              tx_i,
  input  logic              rx_i,
  output logic              rx_o,
  output logic              tx_o,
  output logic              dtr_n_o,
  output logic              rts_n_o,
  output logic              op_n_o,
  output logic              irq_o,
  output logic              irq_oe_o
);
  localparam int CTL_PAD = REG_W - CTL_W;
  localparam int IEN_PAD = REG_W - IEN_W;

  logic             rst_n_int;
  logic [CTL_W-1:0] ctl_q;
  logic [IEN_W-1:0] ien_q;
  mdm_lines_t       pin_raw, pin_lvl, lvl_q, dlt_q;
  logic             loop_on, ctl_we, ien_we, sts_rd;
  logic             unused_wdata;

  assign unused_wdata = ^wdata[REG_W-1:CTL_W];

  mdm_sync #(.WIDTH(1), .STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_int)
  );

  always_comb begin
    pin_raw         = '0;
    pin_raw[LN_DCD] = ~dcd_n_i;
    pin_raw[LN_RI]  = ~ri_n_i;
    pin_raw[LN_DSR] = ~dsr_n_i;
    pin_raw[LN_CTS] = ~cts_n_i;
  end

  mdm_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_psync (
    .clk(clk), .rst_n(rst_n_int), .d(pin_raw), .q(pin_lvl)
  );

  assign ctl_we = wr_en && (addr == ADDR_CTL);
  assign ien_we = wr_en && (addr == ADDR_IEN);
  assign sts_rd = rd_en && (addr == ADDR_STS);

  mdm_regs u_regs (
    .clk(clk), .rst_n(rst_n_int), .ctl_we(ctl_we), .ien_we(ien_we),
    .wbits(wdata[CTL_W-1:0]), .ctl_q(ctl_q), .ien_q(ien_q)
  );

  mdm_status u_sts (
    .clk(clk), .rst_n(rst_n_int), .pin_lvl(pin_lvl), .ctl_q(ctl_q),
    .clr(sts_rd), .lvl_q(lvl_q), .dlt_q(dlt_q)
  );

  assign loop_on  = ctl_q[CB_LOOP];
  assign dtr_n_o  = ~(ctl_q[CB_DTR]  & ~loop_on);
  assign rts_n_o  = ~(ctl_q[CB_RTS]  & ~loop_on);
  assign op_n_o   = ~(ctl_q[CB_OUT2] & ~loop_on);
  assign irq_oe_o = ctl_q[CB_OUT2];
  assign irq_o    = ien_q[IB_MDM] & (|dlt_q);
  assign tx_o     = loop_on | tx_i;
  assign rx_o     = loop_on ? tx_i : rx_i;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CTL)      rdata = {{CTL_PAD{1'b0}}, ctl_q};
    else if (addr == ADDR_IEN) rdata = {{IEN_PAD{1'b0}}, ien_q};
    else if (addr == ADDR_STS) rdata = {lvl_q, dlt_q};
  end
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk import mdm_pkg::*; #(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] ADDR_CTL = 3'd4,
  parameter logic [ADDR_W-1:0] ADDR_STS = 3'd6
) (
  input logic              clk,
  input logic              rst_n_int,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic              tx_i,
  input logic              rx_o,
  input logic              tx_o,
  input logic              dtr_n_o,
  input logic              rts_n_o,
  input logic              op_n_o,
  input logic              irq_o,
  input logic              irq_oe_o,
  input logic [CTL_W-1:0]  ctl_q,
  input logic [IEN_W-1:0]  ien_q,
  input mdm_lines_t        lvl_q,
  input mdm_lines_t        dlt_q
);
  AST_RESET_PINS_IDLE: assert property (@(posedge clk) !rst_n_int |-> (dtr_n_o && rts_n_o && op_n_o && !irq_oe_o)); // R1
  AST_DTR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n_int) (wr_en && addr == ADDR_CTL && !wdata[CB_LOOP]) |=> (dtr_n_o == !$past(wdata[CB_DTR]))); // R2
  AST_RTS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n_int) (wr_en && addr == ADDR_CTL && !wdata[CB_LOOP]) |=> (rts_n_o == !$past(wdata[CB_RTS]))); // R3
  AST_OP_VS_IRQ_OE: assert property (@(posedge clk) disable iff (!rst_n_int) !ctl_q[CB_LOOP] |-> (op_n_o == !irq_oe_o)); // R4
  AST_LOOP_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n_int) ctl_q[CB_LOOP] |-> (tx_o && dtr_n_o && rts_n_o && op_n_o && rx_o == tx_i)); // R5
  AST_LOOP_LEVEL_MAP: assert property (@(posedge clk) disable iff (!rst_n_int) ctl_q[CB_LOOP] |=> (lvl_q == {$past(ctl_q[CB_OUT2]), $past(ctl_q[CB_OUT1]), $past(ctl_q[CB_DTR]), $past(ctl_q[CB_RTS])})); // R6
  AST_RING_TRAILING: assert property (@(posedge clk) disable iff (!rst_n_int) $rose(dlt_q[LN_RI]) |-> $fell(lvl_q[LN_RI])); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_int) (rd_en && addr == ADDR_STS) |=> ($stable(lvl_q) |-> dlt_q == '0)); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n_int) irq_o |-> (ien_q[IB_MDM] && dlt_q != '0)); // R11
endmodule

bind uart_modem_ctl uart_modem_ctl_chk #(.ADDR_W(ADDR_W), .ADDR_CTL(ADDR_CTL), .ADDR_STS(ADDR_STS)) u_chk (
  .clk(clk), .rst_n_int(rst_n_int), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .tx_i(tx_i), .rx_o(rx_o), .tx_o(tx_o), .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o), .op_n_o(op_n_o),
  .irq_o(irq_o), .irq_oe_o(irq_oe_o), .ctl_q(ctl_q), .ien_q(ien_q), .lvl_q(lvl_q), .dlt_q(dlt_q)
);

// File: tb/sim_uart_modem_ctl.sv
module sim_uart_modem_ctl;
  localparam int CLK_P = 10;
  localparam int WDOG  = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic dsr_n = 1'b1, cts_n = 1'b1, dcd_n = 1'b1, ri_n = 1'b1;
  logic tx_i = 1'b1, rx_i = 1'b1;
  logic rx_o, tx_o, dtr_n, rts_n, op_n, irq, irq_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  uart_modem_ctl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .dsr_n_i(dsr_n), .cts_n_i(cts_n), .dcd_n_i(dcd_n), .ri_n_i(ri_n), .tx_i(tx_i), .rx_i(rx_i),
    .rx_o(rx_o), .tx_o(tx_o), .dtr_n_o(dtr_n), .rts_n_o(rts_n), .op_n_o(op_n), .irq_o(irq), .irq_oe_o(irq_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model state
  bit [4:0] m_ctl = 0;
  bit [3:0] m_ien = 0, m_s1 = 0, m_s2 = 0, m_lvl = 0, m_dlt = 0;
  bit m_r1 = 0, m_r2 = 0;

  always @(posedge clk) begin
    bit [3:0] src, set, pins;
    if (!rst_n) begin
      m_ctl = 0; m_ien = 0; m_s1 = 0; m_s2 = 0; m_lvl = 0; m_dlt = 0; m_r1 = 0; m_r2 = 0;
    end else begin
      if (!m_r2) begin
        m_ctl = 0; m_ien = 0; m_s1 = 0; m_s2 = 0; m_lvl = 0; m_dlt = 0;
      end else begin
        pins = {!dcd_n, !ri_n, !dsr_n, !cts_n};
        src = m_ctl[4] ? {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]} : m_s2;
        set = 0;
        for (int i = 0; i < 4; i++)
          if (i == 2) set[i] = m_lvl[i] && !src[i];
          else        set[i] = m_lvl[i] != src[i];
        m_dlt = ((rd_en && addr == 3'd6) ? 4'd0 : m_dlt) | set;
        m_lvl = src;
        m_s2 = m_s1;
        m_s1 = pins;
        if (wr_en && addr == 3'd4) m_ctl = wdata[4:0];
        if (wr_en && addr == 3'd1) m_ien = wdata[3:0];
      end
      m_r2 = m_r1;
      m_r1 = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from both edges
  always @(negedge clk) begin
    #(CLK_P/4);
    if (!done) begin
      bit lb;
      bit [7:0] er;
      lb = m_ctl[4];
      case (addr)
        3'd4: er = {3'b0, m_ctl};
        3'd1: er = {4'b0, m_ien};
        3'd6: er = {m_lvl, m_dlt};
        default: er = 8'h00;
      endcase
      chk("R2 dtr", dtr_n, !(m_ctl[0] && !lb));
      chk("R3 rts", rts_n, !(m_ctl[1] && !lb));
      chk("R4 op", op_n, !(m_ctl[3] && !lb));
      chk("R4 irq_oe", irq_oe, m_ctl[3]);
      chk("R5 tx", tx_o, lb ? 1 : tx_i);
      chk("R5 rx", rx_o, lb ? tx_i : rx_i);
      chk("R11 irq", irq, m_ien[3] && (m_dlt != 0));
      chk("R7 rdata", rdata, er);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit [2:0] a, input bit [7:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0;
  endtask

  task automatic sts_clear();
    addr = 3'd6; rd_en = 1; tick(); rd_en = 0;
  endtask

  task automatic peek(input bit [2:0] a, input string req, input int exp);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    #1 rst_n = 0;
    tick(3);
    chk("R1 dtr in reset", dtr_n, 1);
    chk("R1 irq_oe in reset", irq_oe, 0);
    rst_n = 1;
    tick(4);
    peek(3'd4, "R1 ctl", 0);
    peek(3'd1, "R1 ien", 0);
    peek(3'd6, "R1 sts", 0);
    chk("R1 rts", rts_n, 1);
    chk("R1 op", op_n, 1);

    wr(3'd4, 8'h01); chk("R2 dtr low", dtr_n, 0); chk("R3 rts idle", rts_n, 1);
    wr(3'd4, 8'h02); chk("R2 dtr high", dtr_n, 1); chk("R3 rts low", rts_n, 0);
    wr(3'd4, 8'h08); chk("R4 op low", op_n, 0); chk("R4 oe on", irq_oe, 1);
    wr(3'd4, 8'h00); chk("R4 op high", op_n, 1); chk("R4 oe off", irq_oe, 0);

    wr(3'd4, 8'hEB); peek(3'd4, "R12 ctl readback", 8'h0B);
    wr(3'd1, 8'hF8); peek(3'd1, "R12 ien readback", 8'h08);
    wr(3'd6, 8'hFF); peek(3'd6, "R12 sts write ignored", 8'h00);
    peek(3'd7, "R12 unmapped", 8'h00);
    wr(3'd1, 8'h00); wr(3'd4, 8'h00);

    ri_n = 0; tick(4); peek(3'd6, "R9 ring falling pin", 8'h40);
    ri_n = 1; tick(4); peek(3'd6, "R9 ring rising pin", 8'h04);
    sts_clear(); peek(3'd6, "R10 cleared", 8'h00);

    dsr_n = 0; tick(4); peek(3'd6, "R8 dsr", 8'h22); sts_clear();
    cts_n = 0; tick(4); peek(3'd6, "R8 cts", 8'h31); sts_clear();
    dcd_n = 0; tick(4); peek(3'd6, "R8 dcd", 8'hB8); sts_clear();
    peek(3'd6, "R10 levels kept", 8'hB0);
    dsr_n = 1; cts_n = 1; dcd_n = 1; tick(4); peek(3'd6, "R8 release", 8'h0B); sts_clear();

    wr(3'd1, 8'h08); chk("R11 no flag", irq, 0);
    dsr_n = 0; tick(4); chk("R11 flag", irq, 1);
    sts_clear(); chk("R11 after clear", irq, 0);
    wr(3'd1, 8'h00); dsr_n = 1; tick(4); chk("R11 disabled", irq, 0);
    peek(3'd6, "R7 flag only", 8'h02); sts_clear();

    wr(3'd4, 8'h11); tick(2);
    peek(3'd6, "R6 loop dtr to dsr", 8'h22);
    chk("R5 dtr forced", dtr_n, 1);
    rx_i = 0; tx_i = 1; #1; chk("R5 rx from tx", rx_o, 1); chk("R5 tx idle", tx_o, 1);
    tx_i = 0; #1; chk("R5 rx follows tx", rx_o, 0); chk("R5 tx held", tx_o, 1);
    sts_clear();
    dsr_n = 0; ri_n = 0; tick(4); peek(3'd6, "R6 pins ignored", 8'h20);
    wr(3'd4, 8'h1E); tick(1); peek(3'd6, "R6 loop map", 8'hDB);
    sts_clear();
    wr(3'd4, 8'h00); tick(3);
    dsr_n = 1; ri_n = 1; rx_i = 1; tx_i = 1; tick(4); sts_clear();

    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 15);
      addr = 3'($urandom_range(0, 7));
      wdata = 8'($urandom);
      if (addr == 3'd4 && $urandom_range(0, 3) != 0) wdata[4] = 1'b0;
      wr_en = (r < 3);
      rd_en = (r >= 3 && r < 7);
      if ($urandom_range(0, 3) == 0) begin
        dsr_n = 1'($urandom); cts_n = 1'($urandom); dcd_n = 1'($urandom); ri_n = 1'($urandom);
      end
      tx_i = 1'($urandom); rx_i = 1'($urandom);
      tick();
    end
    wr_en = 0; rd_en = 0;
    tick(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule